// File: doc/BRIEF.md
# SDRAM Command Sequence Monitor

This block watches the command pins of a single-data-rate SDRAM and never drives them. It decodes each clock's command from chip select, the three strobes, the bank bits and the address. It keeps an open or closed flag for each bank, the remaining beats of any burst that precharges its own bank when it ends, and down-counting guard timers for every spacing rule. All timing limits are parameters counted in clocks.

When a command breaks an ordering or spacing rule, the monitor records an error code in a sticky register. The register raises a flag one clock after the offending command. The code stays until the controller under test, or its bench, pulses the clear input. The block is meant to be placed beside a memory controller in simulation or on silicon, to catch protocol slips at the point where they happen.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: During and after a synchronous reset, `err_flag` is 0, `err_code` is 0 and all banks count as closed with no guard timer running.
- R2: The first violation is held in `err_code` with `err_flag` high. Later violations do not change it. A clear removes the record at the next edge. A violation in the same clock as a clear is recorded.
- R3: When one command breaks several rules, the lowest code is recorded.
- R4: A mode-register write or a refresh while any bank is open (this includes a bank still in a self-precharging burst) records code 2.
- R5: Any command other than NOP or deselect in the `MRS_GAP` clocks after a mode-register write records code 1.
- R6: A read or write to a closed bank records code 3. An activate to a bank that is already open records code 6.
- R7: A read or write issued while any self-precharging burst still has beats left records code 4. The first clock that is `BURST_LEN` clocks after that burst's command is legal again.
- R8: An activate to a closed bank records code 7 if it comes too early. After a manual precharge the limit is `TRP` clocks. After a self-precharging read it is `TRP` clocks after the last beat. After a self-precharging write it is `TRDL+TRP` clocks after the last beat.
- R9: Two activates closer than `TRRD` clocks record code 8. A read or write closer than `TRCD` clocks to its bank's activate records code 5.
- R10: A precharge of an open bank sooner than `TRAS` clocks after its activate records code 9. A precharge sooner than `TRDL` clocks after the bank's last write beat (write clock plus `BURST_LEN-1`) records code 10.
- R11: A precharge with address bit `AP_BIT` high closes every bank, whatever the bank bits are.
- R12: Reads and writes to open banks may follow each other on every clock without any error.
- R13: Commands decode with chip select low from {ras_n,cas_n,we_n}: 000 mode write, 001 refresh, 010 precharge, 011 activate, 100 write, 101 read, 110 burst stop, 111 NOP. With chip select high the cycle is a deselect. Address bit `AP_BIT` high on a read or write requests a self-precharging burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock the command bus is sampled on |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BANK_W | Bank select |
| addr | input | ADDR_W | Address; bit AP_BIT is the precharge/all flag |
| err_clear | input | 1 | Drops the stored error at the next edge |
| err_flag | output | 1 | High while an error is stored |
| err_code | output | 4 | Stored error code, 0 when none |

## Verification
The bench drives each rule exactly one clock short of its limit and exactly on it. A design whose guard timer is off by one reports a false error on the legal command, or stays quiet on the illegal one. Self-precharging bursts are tested for both the end of the column lockout and the longer activate delay after a write. A monitor that closed the bank at the burst command, or that ignored the write recovery, would flag the wrong clock. A precharge with the all-banks bit set is given mismatched bank bits, which exposes a decoder that honours them. Overlapping violations and a clear that lands on a violation check the priority and the sticky record.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;

  typedef enum logic [2:0] {
    CMD_NOP, CMD_MRS, CMD_REF, CMD_PRE, CMD_ACT, CMD_WR, CMD_RD, CMD_BST
  } cmd_e;

  typedef enum logic [3:0] {
    ERR_NONE       = 4'd0,
    ERR_MRS_GAP    = 4'd1,
    ERR_NOT_IDLE   = 4'd2,
    ERR_COL_CLOSED = 4'd3,
    ERR_COL_AP     = 4'd4,
    ERR_COL_RCD    = 4'd5,
    ERR_ACT_OPEN   = 4'd6,
    ERR_ACT_RP     = 4'd7,
    ERR_ACT_RRD    = 4'd8,
    ERR_PRE_RAS    = 4'd9,
    ERR_PRE_RDL    = 4'd10
  } err_e;

  // R13: strobe encoding, deselect folds into NOP
  function automatic cmd_e decode_cmd(input logic cs_n, input logic ras_n,
                                      input logic cas_n, input logic we_n);
    cmd_e c;
    if (cs_n) c = CMD_NOP;
    else begin
      case ({ras_n, cas_n, we_n})
        3'b000:  c = CMD_MRS;
        3'b001:  c = CMD_REF;
        3'b010:  c = CMD_PRE;
        3'b011:  c = CMD_ACT;
        3'b100:  c = CMD_WR;
        3'b101:  c = CMD_RD;
        3'b110:  c = CMD_BST;
        default: c = CMD_NOP;
      endcase
    end
    return c;
  endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_mon_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2
) (
  input  logic                 cs_n,
  input  logic                 ras_n,
  input  logic                 cas_n,
  input  logic                 we_n,
  input  logic [BANK_W-1:0]    ba,
  input  logic                 ap_bit,
  output cmd_e                 cmd,
  output logic [NUM_BANKS-1:0] bank_hit,
  output logic [NUM_BANKS-1:0] pre_mask
);

  assign cmd = decode_cmd(cs_n, ras_n, cas_n, we_n);

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_sel
    assign bank_hit[i] = (ba == BANK_W'(i));
    // R11: all-banks precharge ignores the bank bits
    assign pre_mask[i] = ap_bit | bank_hit[i];
  end

endmodule

// File: rtl/sdram_bank_state.sv
module sdram_bank_state #(
  parameter int TRCD      = 3,
  parameter int TRAS      = 6,
  parameter int TRP       = 3,
  parameter int TRDL      = 2,
  parameter int BURST_LEN = 4,
  parameter int TW        = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic act_hit,
  input  logic col_hit,
  input  logic col_wr,
  input  logic col_ap,
  input  logic pre_hit,
  output logic open_o,
  output logic rcd_busy,
  output logic ras_busy,
  output logic rp_busy,
  output logic rdl_busy,
  output logic ap_busy
);

  localparam logic [TW-1:0] L_RCD  = TW'(TRCD - 1);
  localparam logic [TW-1:0] L_RAS  = TW'(TRAS - 1);
  localparam logic [TW-1:0] L_RP   = TW'(TRP - 1);
  localparam logic [TW-1:0] L_DAL  = TW'(TRDL + TRP - 1);
  localparam logic [TW-1:0] L_RDL  = TW'(BURST_LEN - 1 + TRDL - 1);
  localparam logic [TW-1:0] L_BEAT = TW'(BURST_LEN - 1);
  localparam logic [TW-1:0] ONE    = TW'(1);

  logic          open_q, ap_wr_q;
  logic [TW-1:0] rcd_t, ras_t, rp_t, rdl_t, ap_t;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q  <= 1'b0;
      ap_wr_q <= 1'b0;
      rcd_t   <= '0;
      ras_t   <= '0;
      rp_t    <= '0;
      rdl_t   <= '0;
      ap_t    <= '0;
    end else begin
      if (rcd_t != '0) rcd_t <= rcd_t - ONE;
      if (ras_t != '0) ras_t <= ras_t - ONE;
      if (rp_t  != '0) rp_t  <= rp_t  - ONE;
      if (rdl_t != '0) rdl_t <= rdl_t - ONE;

      // last beat of a self-precharging burst closes the bank
      if (ap_t == ONE) begin
        ap_t   <= '0;
        open_q <= 1'b0;
        rp_t   <= ap_wr_q ? L_DAL : L_RP;
      end else if (ap_t != '0) begin
        ap_t <= ap_t - ONE;
      end

      if (act_hit) begin
        open_q <= 1'b1;
        rcd_t  <= L_RCD;
        ras_t  <= L_RAS;
      end

      if (col_hit && open_q) begin
        if (col_wr) rdl_t <= L_RDL;
        if (col_ap) begin
          if (BURST_LEN == 1) begin
            open_q <= 1'b0;
            rp_t   <= col_wr ? L_DAL : L_RP;
          end else begin
            open_q  <= 1'b1;
            ap_t    <= L_BEAT;
            ap_wr_q <= col_wr;
          end
        end
      end

      if (pre_hit && open_q) begin
        open_q <= 1'b0;
        ap_t   <= '0;
        rp_t   <= L_RP;
      end
    end
  end

  assign open_o   = open_q;
  assign rcd_busy = (rcd_t != '0);
  assign ras_busy = (ras_t != '0);
  assign rp_busy  = (rp_t  != '0);
  assign rdl_busy = (rdl_t != '0);
  assign ap_busy  = (ap_t  != '0);

endmodule

// File: rtl/sdram_rule_check.sv
module sdram_rule_check
  import sdram_mon_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int TRRD      = 2,
  parameter int MRS_GAP   = 2,
  parameter int TW        = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  cmd_e                 cmd,
  input  logic [NUM_BANKS-1:0] bank_hit,
  input  logic [NUM_BANKS-1:0] pre_mask,
  input  logic [NUM_BANKS-1:0] open_v,
  input  logic [NUM_BANKS-1:0] rcd_v,
  input  logic [NUM_BANKS-1:0] ras_v,
  input  logic [NUM_BANKS-1:0] rp_v,
  input  logic [NUM_BANKS-1:0] rdl_v,
  input  logic [NUM_BANKS-1:0] ap_v,
  output logic                 viol,
  output err_e                 code
);

  localparam logic [TW-1:0] L_RRD = TW'(TRRD - 1);
  localparam logic [TW-1:0] L_GAP = TW'(MRS_GAP);
  localparam logic [TW-1:0] ONE   = TW'(1);

  logic [TW-1:0] rrd_t, gap_t;

  always_ff @(posedge clk) begin
    if (rst) begin
      rrd_t <= '0;
      gap_t <= '0;
    end else begin
      if (cmd == CMD_ACT)   rrd_t <= L_RRD;
      else if (rrd_t != '0) rrd_t <= rrd_t - ONE;
      if (cmd == CMD_MRS)   gap_t <= L_GAP;
      else if (gap_t != '0) gap_t <= gap_t - ONE;
    end
  end

  logic is_col, is_act, is_pre;
  logic v_gap, v_idle, v_closed, v_ap, v_rcd, v_open, v_rp, v_rrd, v_ras, v_rdl;

  always_comb begin
    is_col   = (cmd == CMD_RD) || (cmd == CMD_WR);
    is_act   = (cmd == CMD_ACT);
    is_pre   = (cmd == CMD_PRE);
    v_gap    = (gap_t != '0) && (cmd != CMD_NOP);
    v_idle   = ((cmd == CMD_MRS) || (cmd == CMD_REF)) && (|open_v);
    v_closed = is_col && !(|(bank_hit & open_v));
    v_ap     = is_col && (|ap_v);
    v_rcd    = is_col && (|(bank_hit & open_v & rcd_v));
    v_open   = is_act && (|(bank_hit & open_v));
    v_rp     = is_act && (|(bank_hit & ~open_v & rp_v));
    v_rrd    = is_act && (rrd_t != '0);
    v_ras    = is_pre && (|(pre_mask & open_v & ras_v));
    v_rdl    = is_pre && (|(pre_mask & open_v & rdl_v));

    // R3: lowest code wins
    if      (v_gap)    code = ERR_MRS_GAP;
    else if (v_idle)   code = ERR_NOT_IDLE;
    else if (v_closed) code = ERR_COL_CLOSED;
    else if (v_ap)     code = ERR_COL_AP;
    else if (v_rcd)    code = ERR_COL_RCD;
    else if (v_open)   code = ERR_ACT_OPEN;
    else if (v_rp)     code = ERR_ACT_RP;
    else if (v_rrd)    code = ERR_ACT_RRD;
    else if (v_ras)    code = ERR_PRE_RAS;
    else if (v_rdl)    code = ERR_PRE_RDL;
    else               code = ERR_NONE;
    viol = (code != ERR_NONE);
  end

endmodule

// File: rtl/sdram_err_latch.sv
module sdram_err_latch
  import sdram_mon_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       clear,
  input  logic       viol,
  input  err_e       code_in,
  output logic       flag,
  output logic [3:0] code_out
);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag     <= 1'b0;
      code_out <= 4'd0;
    end else if (clear || !flag) begin
      flag     <= viol;
      code_out <= viol ? code_in : 4'd0;
    end
  end

endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
  import sdram_mon_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2,
  parameter int ADDR_W    = 13,
  parameter int AP_BIT    = 10,
  parameter int TRRD      = 2,
  parameter int TRCD      = 3,
  parameter int TRP       = 3,
  parameter int TRAS      = 6,
  parameter int TRDL      = 2,
  parameter int BURST_LEN = 4,
  parameter int MRS_GAP   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [BANK_W-1:0] ba,
  input  logic [ADDR_W-1:0] addr,
  input  logic              err_clear,
  output logic              err_flag,
  output logic [3:0]        err_code
);

  localparam int TW = $clog2(BURST_LEN + TRDL + TRP + TRAS + TRCD + TRRD + MRS_GAP + 1);

  cmd_e                 cmd;
  logic [NUM_BANKS-1:0] bank_hit, pre_mask;
  logic [NUM_BANKS-1:0] bank_open, rcd_v, ras_v, rp_v, rdl_v, ap_v;
  logic                 viol;
  err_e                 viol_code;
  logic                 ap_bit;

  assign ap_bit = addr[AP_BIT];

  sdram_cmd_decode #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_dec (
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .ap_bit(ap_bit),
    .cmd(cmd), .bank_hit(bank_hit), .pre_mask(pre_mask)
  );

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    sdram_bank_state #(
      .TRCD(TRCD), .TRAS(TRAS), .TRP(TRP), .TRDL(TRDL),
      .BURST_LEN(BURST_LEN), .TW(TW)
    ) u_bank (
      .clk(clk), .rst(rst),
      .act_hit(cmd == CMD_ACT && bank_hit[i]),
      .col_hit((cmd == CMD_RD || cmd == CMD_WR) && bank_hit[i]),
      .col_wr(cmd == CMD_WR),
      .col_ap(ap_bit),
      .pre_hit(cmd == CMD_PRE && pre_mask[i]),
      .open_o(bank_open[i]),
      .rcd_busy(rcd_v[i]), .ras_busy(ras_v[i]), .rp_busy(rp_v[i]),
      .rdl_busy(rdl_v[i]), .ap_busy(ap_v[i])
    );
  end

  sdram_rule_check #(
    .NUM_BANKS(NUM_BANKS), .TRRD(TRRD), .MRS_GAP(MRS_GAP), .TW(TW)
  ) u_rules (
    .clk(clk), .rst(rst), .cmd(cmd),
    .bank_hit(bank_hit), .pre_mask(pre_mask),
    .open_v(bank_open), .rcd_v(rcd_v), .ras_v(ras_v), .rp_v(rp_v),
    .rdl_v(rdl_v), .ap_v(ap_v),
    .viol(viol), .code(viol_code)
  );

  sdram_err_latch u_latch (
    .clk(clk), .rst(rst), .clear(err_clear),
    .viol(viol), .code_in(viol_code),
    .flag(err_flag), .code_out(err_code)
  );

endmodule

// File: rtl/sdram_cmd_monitor_chk.sv
module sdram_cmd_monitor_chk #(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2,
  parameter int ADDR_W    = 13,
  parameter int AP_BIT    = 10
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 cs_n,
  input logic                 ras_n,
  input logic                 cas_n,
  input logic                 we_n,
  input logic [BANK_W-1:0]    ba,
  input logic [ADDR_W-1:0]    addr,
  input logic                 err_clear,
  input logic                 err_flag,
  input logic [3:0]           err_code,
  input logic [NUM_BANKS-1:0] bank_open
);

  logic c_mrs, c_pre, c_col, c_idle;
  assign c_mrs  = !cs_n && !ras_n && !cas_n && !we_n;
  assign c_pre  = !cs_n && !ras_n &&  cas_n && !we_n;
  assign c_col  = !cs_n &&  ras_n && !cas_n;
  assign c_idle = cs_n || (ras_n && cas_n && we_n);

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!err_flag && err_code == 4'd0)); // R1

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (err_flag && !err_clear) |=> (err_flag && $stable(err_code))); // R2

  AST_CLEAR_ON_IDLE: assert property (@(posedge clk) disable iff (rst)
    (err_clear && cs_n) |=> !err_flag); // R2

  AST_CODE_RANGE: assert property (@(posedge clk) disable iff (rst)
    err_flag |-> (err_code != 4'd0 && err_code <= 4'd10)); // R3

  AST_MRS_GAP: assert property (@(posedge clk) disable iff (rst)
    (c_mrs && !err_flag && !err_clear) ##1 (!c_idle && !err_clear) |=> err_flag); // R5

  AST_COL_CLOSED: assert property (@(posedge clk) disable iff (rst)
    (c_col && !bank_open[ba] && !err_flag && !err_clear) |=> err_flag); // R6

  AST_PRE_ALL: assert property (@(posedge clk) disable iff (rst)
    (c_pre && addr[AP_BIT]) |=> (bank_open == '0)); // R11

endmodule

bind sdram_cmd_monitor sdram_cmd_monitor_chk #(
  .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .ADDR_W(ADDR_W), .AP_BIT(AP_BIT)
) u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
  .we_n(we_n), .ba(ba), .addr(addr), .err_clear(err_clear),
  .err_flag(err_flag), .err_code(err_code), .bank_open(bank_open)
);

// File: tb/sdram_cmd_monitor_tb.sv
module sdram_cmd_monitor_tb;

  localparam int TRRD = 2, TRCD = 3, TRP = 3, TRAS = 6, TRDL = 2, BL = 4, GAP = 2;
  localparam int K_NOP = 0, K_MRS = 1, K_REF = 2, K_PRE = 3, K_ACT = 4,
                 K_WR = 5, K_RD = 6, K_BST = 7, K_DES = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0]  ba = 2'd0;
  logic [12:0] addr = 13'd0;
  logic        err_clear = 1'b0;
  logic        err_flag;
  logic [3:0]  err_code;

  int checks = 0, fails = 0, cyc = 0;
  string cur_req = "R1";

  // reference model state, absolute cycle times
  bit m_open[4], m_ap[4], m_apwr[4];
  int m_act[4], m_rprdy[4], m_rdlrdy[4], m_apend[4];
  int m_lastact = -1000, m_mrs = -1000;
  bit exp_flag = 0;
  int exp_code = 0;

  always #2.5 clk = ~clk;

  sdram_cmd_monitor u_dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr(addr), .err_clear(err_clear),
    .err_flag(err_flag), .err_code(err_code)
  );

  initial begin
    #(5.0 * 200000);
    fails++; checks++;
    $display("FAIL watchdog %s: actual=timeout expected=finish", cur_req);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  function automatic int model_eval(int k, int b, bit a10);
    int c = cyc;
    bit any_open = 0, any_ap = 0;
    int v = 0;
    for (int i = 0; i < 4; i++) begin
      if (m_ap[i] && c > m_apend[i]) begin
        m_ap[i] = 0; m_open[i] = 0;
        m_rprdy[i] = m_apend[i] + (m_apwr[i] ? TRDL + TRP : TRP);
      end
    end
    for (int i = 0; i < 4; i++) begin
      any_open |= m_open[i];
      any_ap   |= m_ap[i];
    end
    if (c > m_mrs && c <= m_mrs + GAP && k != K_NOP && k != K_DES) v = 1;
    else if ((k == K_MRS || k == K_REF) && any_open) v = 2;
    else if ((k == K_RD || k == K_WR) && !m_open[b]) v = 3;
    else if ((k == K_RD || k == K_WR) && any_ap) v = 4;
    else if ((k == K_RD || k == K_WR) && c < m_act[b] + TRCD) v = 5;
    else if (k == K_ACT && m_open[b]) v = 6;
    else if (k == K_ACT && c < m_rprdy[b]) v = 7;
    else if (k == K_ACT && c < m_lastact + TRRD) v = 8;
    else if (k == K_PRE) begin
      for (int i = 0; i < 4; i++)
        if ((a10 || i == b) && m_open[i] && c < m_act[i] + TRAS) v = 9;
      if (v == 0)
        for (int i = 0; i < 4; i++)
          if ((a10 || i == b) && m_open[i] && c < m_rdlrdy[i]) v = 10;
    end
    // state update
    case (k)
      K_ACT: begin m_open[b] = 1; m_act[b] = c; m_lastact = c; end
      K_RD, K_WR: if (m_open[b]) begin
        if (k == K_WR) m_rdlrdy[b] = c + BL - 1 + TRDL;
        if (a10) begin m_ap[b] = 1; m_apend[b] = c + BL - 1; m_apwr[b] = (k == K_WR); end
      end
      K_PRE: for (int i = 0; i < 4; i++)
        if ((a10 || i == b) && m_open[i]) begin
          m_open[i] = 0; m_ap[i] = 0; m_rprdy[i] = c + TRP;
        end
      K_MRS: m_mrs = c;
      default: ;
    endcase
    return v;
  endfunction

  task automatic issue(int k, int b = 0, bit a10 = 0, bit clr = 0);
    int v;
    cs_n = (k == K_DES);
    case (k)
      K_MRS: {ras_n, cas_n, we_n} = 3'b000;
      K_REF: {ras_n, cas_n, we_n} = 3'b001;
      K_PRE: {ras_n, cas_n, we_n} = 3'b010;
      K_ACT: {ras_n, cas_n, we_n} = 3'b011;
      K_WR:  {ras_n, cas_n, we_n} = 3'b100;
      K_RD:  {ras_n, cas_n, we_n} = 3'b101;
      K_BST: {ras_n, cas_n, we_n} = 3'b110;
      default: {ras_n, cas_n, we_n} = 3'b111;
    endcase
    ba = 2'(b);
    addr = 13'h0;
    addr[10] = a10;
    err_clear = clr;
    v = model_eval(k, b, a10);
    if (clr || !exp_flag) begin
      exp_flag = (v != 0);
      exp_code = v;
    end
    @(posedge clk); #1;
    cyc++;
    checks++;
    if (err_flag !== exp_flag || err_code !== 4'(exp_code)) begin
      fails++;
      $display("FAIL %s cycle %0d: actual flag=%0b code=%0d expected flag=%0b code=%0d",
               cur_req, cyc, err_flag, err_code, exp_flag, exp_code);
    end
    cs_n = 1'b1; err_clear = 1'b0;
  endtask

  task automatic nop(int n);
    for (int i = 0; i < n; i++) issue(K_NOP);
  endtask

  task automatic expect_code(int code, string req);
    checks++;
    if (err_code !== 4'(code) || err_flag !== (code != 0)) begin
      fails++;
      $display("FAIL %s: actual flag=%0b code=%0d expected code=%0d",
               req, err_flag, err_code, code);
    end
  endtask

  task automatic settle();
    nop(8);
    issue(K_PRE, 0, 1);
    nop(8);
    issue(K_NOP, 0, 0, 1);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin
      m_open[i] = 0; m_ap[i] = 0; m_apwr[i] = 0;
      m_act[i] = -1000; m_rprdy[i] = 0; m_rdlrdy[i] = 0; m_apend[i] = 0;
    end
    repeat (3) @(posedge clk);
    #1;
    cur_req = "R1";
    expect_code(0, "R1");
    rst = 1'b0;
    nop(2);
    expect_code(0, "R1");

    cur_req = "R12"; // R13 encodings exercised throughout
    issue(K_ACT, 0); nop(2);
    issue(K_RD, 0); issue(K_WR, 0); issue(K_RD, 0); issue(K_RD, 0);
    expect_code(0, "R12");
    cur_req = "R13";
    issue(K_BST); issue(K_DES); issue(K_RD, 0);
    expect_code(0, "R13");
    settle();

    cur_req = "R9";
    issue(K_ACT, 1); nop(1); issue(K_RD, 1);
    expect_code(5, "R9");
    settle();
    issue(K_ACT, 2); issue(K_ACT, 3);
    expect_code(8, "R9");
    settle();
    issue(K_ACT, 2); nop(1); issue(K_ACT, 3); nop(2); issue(K_WR, 3);
    expect_code(0, "R9");
    settle();

    cur_req = "R10";
    issue(K_ACT, 0); nop(2); issue(K_PRE, 0);
    expect_code(9, "R10");
    settle();
    issue(K_ACT, 0); nop(6); issue(K_WR, 0); nop(3); issue(K_PRE, 0);
    expect_code(10, "R10");
    settle();
    issue(K_ACT, 0); nop(6); issue(K_WR, 0); nop(4); issue(K_PRE, 0);
    expect_code(0, "R10");
    settle();

    cur_req = "R6";
    issue(K_RD, 2);
    expect_code(3, "R6");
    settle();
    issue(K_ACT, 1); nop(3); issue(K_ACT, 1);
    expect_code(6, "R6");
    settle();

    cur_req = "R4";
    issue(K_ACT, 0); nop(4); issue(K_MRS);
    expect_code(2, "R4");
    settle();
    issue(K_ACT, 0); nop(4); issue(K_REF);
    expect_code(2, "R4");
    settle();

    cur_req = "R5";
    issue(K_MRS); issue(K_ACT, 0);
    expect_code(1, "R5");
    settle();
    issue(K_MRS); nop(2); issue(K_ACT, 0);
    expect_code(0, "R5");
    settle();

    cur_req = "R3";
    issue(K_MRS); issue(K_RD, 1);
    expect_code(1, "R3");
    settle();

    cur_req = "R7";
    issue(K_ACT, 0); nop(1); issue(K_ACT, 1); nop(2);
    issue(K_RD, 0, 1); issue(K_RD, 1);
    expect_code(4, "R7");
    settle();
    issue(K_ACT, 0); nop(1); issue(K_ACT, 1); nop(2);
    issue(K_RD, 0, 1); nop(3); issue(K_RD, 1);
    expect_code(0, "R7");
    settle();

    cur_req = "R8";
    issue(K_ACT, 0); nop(3); issue(K_RD, 0, 1); nop(4); issue(K_ACT, 0);
    expect_code(7, "R8");
    settle();
    issue(K_ACT, 0); nop(3); issue(K_RD, 0, 1); nop(5); issue(K_ACT, 0);
    expect_code(0, "R8");
    settle();
    issue(K_ACT, 0); nop(3); issue(K_WR, 0, 1); nop(5); issue(K_ACT, 0);
    expect_code(7, "R8");
    settle();
    issue(K_ACT, 0); nop(6); issue(K_PRE, 0); nop(1); issue(K_ACT, 0);
    expect_code(7, "R8");
    settle();

    cur_req = "R11";
    issue(K_ACT, 0); nop(1); issue(K_ACT, 2); nop(6);
    issue(K_PRE, 3, 1); nop(3); issue(K_RD, 0);
    expect_code(3, "R11");
    settle();

    cur_req = "R2";
    issue(K_RD, 2); issue(K_ACT, 1); nop(1); issue(K_ACT, 1);
    expect_code(3, "R2");
    issue(K_NOP, 0, 0, 1);
    expect_code(0, "R2");
    issue(K_RD, 3); nop(1); issue(K_ACT, 1, 0, 1);
    expect_code(6, "R2");
    settle();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule